// File: doc/BRIEF.md
# Two-Level Trigger Sequence Emulator

This block produces a test stream of two-level trigger decisions. Every cycle a free-running bunch counter advances and a pseudo-random generator decides whether a first-level (L0) accept is issued. Each accept leaves the block tagged with the bunch number of its cycle and a sequential event number. Accepted events are queued in a small FIFO together with the time they were accepted. Each one then returns as a second-level (L1) decision once a programmable latency has elapsed. Each L1 decision carries an accept/reject bit drawn from a second pseudo-random source and the two low bits of the event's bunch number.

The configuration inputs set the orbit length, both decision rates, the L1 latency and a minimum spacing between L1 decisions. They are expected to be driven from configuration registers outside the block. While the queue is full, new L0 accepts are suppressed, so no event is ever lost. Reset is synchronous and active high.

Top module: `trig_seq_emu`

## Requirements
- R1: While `rst` is high at a clock edge, `l0Valid` and `l1Valid` are low after that edge. After reset the bunch counter restarts at 0, the event number restarts at 0, the queue is empty, and both generators are reloaded with their seeds.
- R2: The bunch counter advances by one every cycle and returns to 0 in the cycle after it equals `cfgBidMax`. `l0Bid` is the counter value in the cycle the accept was decided.
- R3: The first accept after reset carries event number 0. Each later accept carries the previous one plus one, modulo 2^13.
- R4: The L0 generator is a 16-bit Galois LFSR that shifts right every cycle: next = (x >> 1) XOR (x[0] ? 0xB400 : 0), seeded with 0xACE1. An accept is decided in a cycle when the LFSR value is below `cfgL0Thresh` and the queue is not full. With a threshold of 0, no accepts occur.
- R5: The queue holds at most DEPTH (default 8) events. In a cycle where it already holds DEPTH events, no L0 accept is issued, even if an event leaves in that same cycle.
- R6: Events leave the queue in accept order. The L1 decision for an event appears no earlier than max(`cfgLatency`,1) cycles after its `l0Valid`.
- R7: The oldest queued event is released in the first cycle in which both of these hold: (a) the current time minus its accept time, modulo 2^16, is at least `cfgLatency`; (b) at least `cfgSpacing` cycles have passed since the previous release. Before the first release after reset, condition (b) always holds. `l1Valid` is high for one cycle, one edge after the release.
- R8: Two consecutive `l1Valid` pulses are at least max(`cfgSpacing`,1) cycles apart.
- R9: `l1Bid` equals bits [1:0] of the bunch number of the released event.
- R10: `l1Accept` is 1 when a second LFSR is below `cfgL1Thresh` in the release cycle. This LFSR uses the same step rule as R4, is seeded with 0x1D2B, and advances every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgBidMax | input | 12 | Last bunch number before the counter wraps |
| cfgL0Thresh | input | 16 | L0 accept threshold against the first LFSR |
| cfgL1Thresh | input | 16 | L1 accept threshold against the second LFSR |
| cfgLatency | input | 16 | Minimum residence time in the queue, in cycles |
| cfgSpacing | input | 16 | Minimum cycles between L1 releases |
| l0Valid | output | 1 | One-cycle L0 accept pulse |
| l0Bid | output | 12 | Bunch number of the accept |
| l0Evt | output | 13 | Event number of the accept |
| l1Valid | output | 1 | One-cycle L1 decision pulse |
| l1Accept | output | 1 | L1 accept (1) or reject (0) |
| l1Bid | output | 2 | Low two bits of the event's bunch number |

## Verification
The bench drives the queue into the full state with a near-certain accept rate and a long latency. A design that let the generator write into a full queue would overwrite a waiting event, or skip an event number. Phases with zero latency and zero spacing check that releases happen back to back, one cycle after the accept. An off-by-one in the age or gap comparison would move each `l1Valid` by a cycle against the reference model. Very short orbits (length 1 and 4) check the wrap of the bunch counter, where a wrap one count late would show up at once in `l0Bid` and `l1Bid`. A final reset in mid-run checks that queued events are discarded and that the numbering restarts.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int BID_W   = 12;
  localparam int EVT_W   = 13;
  localparam int TS_W    = 16;
  localparam int RND_W   = 16;
  localparam int L1BID_W = 2;

  localparam logic [RND_W-1:0] RND_MASK = 16'hB400;
  localparam logic [RND_W-1:0] SEED_L0  = 16'hACE1;
  localparam logic [RND_W-1:0] SEED_L1  = 16'h1D2B;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic l1Acc;
  } strobe_t;

  // one queued event
  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [BID_W-1:0] bid;
  } entry_t;

  function automatic logic [RND_W-1:0] rndStep(input logic [RND_W-1:0] x);
    return (x >> 1) ^ (x[0] ? RND_MASK : '0);
  endfunction
endpackage

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BID_W-1:0] cfgBidMax,
  input  logic [RND_W-1:0] cfgL0Thresh,
  input  logic [RND_W-1:0] cfgL1Thresh,
  input  logic [TS_W-1:0]  cfgLatency,
  input  logic [TS_W-1:0]  cfgSpacing,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [TS_W-1:0]  headTs,
  output strobe_t          strobes,
  output logic [BID_W-1:0] bidNow,
  output logic [TS_W-1:0]  timeNow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [TS_W-1:0]  GAP_SAT  = '1;

  logic [RND_W-1:0] rndL0, rndL1;
  logic [TS_W-1:0]  gapCnt;
  logic [TS_W-1:0]  headAge;
  logic             fifoFull, fifoEmpty;
  logic             ageOk, gapOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      bidNow  <= '0;
      timeNow <= '0;
      rndL0   <= SEED_L0;
      rndL1   <= SEED_L1;
      gapCnt  <= GAP_SAT;
    end else begin
      bidNow  <= (bidNow == cfgBidMax) ? '0 : bidNow + 1'b1;
      timeNow <= timeNow + 1'b1;
      rndL0   <= rndStep(rndL0);
      rndL1   <= rndStep(rndL1);
      if (strobes.pop)
        gapCnt <= TS_W'(1);
      else if (gapCnt != GAP_SAT)
        gapCnt <= gapCnt + 1'b1;
    end
  end

  always_comb begin
    fifoFull      = (fifoCount == FULL_CNT);
    fifoEmpty     = (fifoCount == '0);
    headAge       = timeNow - headTs;
    ageOk         = (headAge >= cfgLatency);
    gapOk         = (gapCnt >= cfgSpacing);
    strobes.push  = (rndL0 < cfgL0Thresh) && !fifoFull;
    strobes.pop   = !fifoEmpty && ageOk && gapOk;
    strobes.l1Acc = (rndL1 < cfgL1Thresh);
  end

  // R2
  bid_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (bidNow == cfgBidMax) |=> (bidNow == '0));

  // R8
  l1_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.pop && cfgSpacing > TS_W'(1)) |=> (!strobes.pop || cfgSpacing <= TS_W'(1)));

  // R4
  no_l0_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgL0Thresh == '0) |-> !strobes.push);
endmodule

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobes,
  input  logic [BID_W-1:0]   bidNow,
  input  logic [TS_W-1:0]    timeNow,
  output logic [CNT_W-1:0]   fifoCount,
  output logic [TS_W-1:0]    headTs,
  output logic               l0Valid,
  output logic [BID_W-1:0]   l0Bid,
  output logic [EVT_W-1:0]   l0Evt,
  output logic               l1Valid,
  output logic               l1Accept,
  output logic [L1BID_W-1:0] l1Bid
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [EVT_W-1:0] evtCnt;
  entry_t           headEntry;

  assign headEntry = mem[rdPtr];
  assign headTs    = headEntry.ts;

  always_ff @(posedge clk) begin
    if (strobes.push)
      mem[wrPtr] <= '{ts: timeNow, bid: bidNow};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
      evtCnt    <= '0;
    end else begin
      if (strobes.push)
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strobes.pop)
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({strobes.push, strobes.pop})
        2'b10:   fifoCount <= fifoCount + 1'b1;
        2'b01:   fifoCount <= fifoCount - 1'b1;
        default: fifoCount <= fifoCount;
      endcase
      if (strobes.push)
        evtCnt <= evtCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l0Valid  <= 1'b0;
      l0Bid    <= '0;
      l0Evt    <= '0;
      l1Valid  <= 1'b0;
      l1Accept <= 1'b0;
      l1Bid    <= '0;
    end else begin
      l0Valid  <= strobes.push;
      l0Bid    <= bidNow;
      l0Evt    <= evtCnt;
      l1Valid  <= strobes.pop;
      l1Accept <= strobes.l1Acc;
      l1Bid    <= headEntry.bid[L1BID_W-1:0];
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.push |-> (fifoCount < CNT_W'(DEPTH)));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.pop |-> (fifoCount != '0));

  // R3
  evt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (l0Valid && strobes.push) |=> (l0Evt == $past(l0Evt) + 1'b1));
endmodule

// File: rtl/trig_seq_emu.sv
module trig_seq_emu
  import trig_seq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BID_W-1:0]   cfgBidMax,
  input  logic [RND_W-1:0]   cfgL0Thresh,
  input  logic [RND_W-1:0]   cfgL1Thresh,
  input  logic [TS_W-1:0]    cfgLatency,
  input  logic [TS_W-1:0]    cfgSpacing,
  output logic               l0Valid,
  output logic [BID_W-1:0]   l0Bid,
  output logic [EVT_W-1:0]   l0Evt,
  output logic               l1Valid,
  output logic               l1Accept,
  output logic [L1BID_W-1:0] l1Bid
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  strobe_t          strobes;
  logic [CNT_W-1:0] fifoCount;
  logic [TS_W-1:0]  headTs;
  logic [BID_W-1:0] bidNow;
  logic [TS_W-1:0]  timeNow;

  trig_seq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfgBidMax(cfgBidMax), .cfgL0Thresh(cfgL0Thresh), .cfgL1Thresh(cfgL1Thresh),
    .cfgLatency(cfgLatency), .cfgSpacing(cfgSpacing),
    .fifoCount(fifoCount), .headTs(headTs),
    .strobes(strobes), .bidNow(bidNow), .timeNow(timeNow)
  );

  trig_seq_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst),
    .strobes(strobes), .bidNow(bidNow), .timeNow(timeNow),
    .fifoCount(fifoCount), .headTs(headTs),
    .l0Valid(l0Valid), .l0Bid(l0Bid), .l0Evt(l0Evt),
    .l1Valid(l1Valid), .l1Accept(l1Accept), .l1Bid(l1Bid)
  );
endmodule

// File: tb/trig_seq_emu_bench.sv
`timescale 1ns/1ps
module trig_seq_emu_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] cfgBidMax = 12'd4095;
  logic [15:0] cfgL0Thresh = 16'h0;
  logic [15:0] cfgL1Thresh = 16'h0;
  logic [15:0] cfgLatency = 16'd5;
  logic [15:0] cfgSpacing = 16'd2;
  logic        l0Valid, l1Valid, l1Accept;
  logic [11:0] l0Bid;
  logic [12:0] l0Evt;
  logic [1:0]  l1Bid;

  trig_seq_emu #(.DEPTH(DEPTH)) u_trig_seq_emu (
    .clk(clk), .rst(rst),
    .cfgBidMax(cfgBidMax), .cfgL0Thresh(cfgL0Thresh), .cfgL1Thresh(cfgL1Thresh),
    .cfgLatency(cfgLatency), .cfgSpacing(cfgSpacing),
    .l0Valid(l0Valid), .l0Bid(l0Bid), .l0Evt(l0Evt),
    .l1Valid(l1Valid), .l1Accept(l1Accept), .l1Bid(l1Bid)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stepRnd(input logic [15:0] x);
    return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
  endfunction

  // ---------------- reference model, advanced on every rising edge
  logic [11:0] mBid;
  logic [15:0] mNow, mRa, mRb, mSince;
  logic [12:0] mEvt;
  logic [15:0] qTs[$];
  logic [11:0] qBid[$];
  bit          eL0V, eL1V, eL1A, armed = 1'b0;
  logic [11:0] eL0Bid;
  logic [12:0] eL0Evt;
  logic [1:0]  eL1Bid;

  always @(posedge clk) begin
    bit acc, rel;
    logic [15:0] age;
    armed <= 1'b1;
    if (rst) begin
      mBid = '0; mNow = '0; mRa = 16'hACE1; mRb = 16'h1D2B;
      mEvt = '0; mSince = 16'hFFFF;
      qTs.delete(); qBid.delete();
      eL0V = 1'b0; eL1V = 1'b0;
    end else begin
      acc = (mRa < cfgL0Thresh) && (qTs.size() < DEPTH);
      rel = 1'b0;
      if (qTs.size() > 0) begin
        age = mNow - qTs[0];
        rel = (age >= cfgLatency) && (mSince >= cfgSpacing);
      end
      eL0V = acc; eL0Bid = mBid; eL0Evt = mEvt;
      eL1V = rel; eL1A = (mRb < cfgL1Thresh);
      if (rel) begin
        eL1Bid = qBid[0][1:0];
        void'(qTs.pop_front());
        void'(qBid.pop_front());
        mSince = 16'd1;
      end else if (mSince != 16'hFFFF) begin
        mSince = mSince + 16'd1;
      end
      if (acc) begin
        qTs.push_back(mNow);
        qBid.push_back(mBid);
        mEvt = mEvt + 13'd1;
      end
      mBid = (mBid == cfgBidMax) ? 12'd0 : mBid + 12'd1;
      mNow = mNow + 16'd1;
      mRa  = stepRnd(mRa);
      mRb  = stepRnd(mRb);
    end
  end

  // ---------------- comparison and order/timing checks at falling edges
  longint cyc = 0;
  longint l0Times[$];
  longint lastL1 = -1;
  int     outstanding = 0;

  always @(negedge clk) begin
    longint t0, minLat, minGap;
    cyc++;
    if (armed) begin
      if (rst) begin
        // R1: outputs quiet during reset
        check(!l0Valid && !l1Valid, "R1", "valid outputs in reset", {l0Valid, l1Valid}, 0);
        l0Times.delete(); lastL1 = -1; outstanding = 0;
      end else begin
        // R4 / R5: accept decision
        check(l0Valid == eL0V, "R4", "l0Valid", l0Valid, eL0V);
        if (l0Valid && eL0V) begin
          check(l0Bid == eL0Bid, "R2", "l0Bid", l0Bid, eL0Bid);
          check(l0Evt == eL0Evt, "R3", "l0Evt", l0Evt, eL0Evt);
        end
        // R7: release timing
        check(l1Valid == eL1V, "R7", "l1Valid", l1Valid, eL1V);
        if (l1Valid && eL1V) begin
          check(l1Bid == eL1Bid, "R9", "l1Bid", l1Bid, eL1Bid);
          check(l1Accept == eL1A, "R10", "l1Accept", l1Accept, eL1A);
        end
        if (l0Valid) begin
          l0Times.push_back(cyc);
          outstanding++;
        end
        if (l1Valid) begin
          outstanding--;
          minLat = (cfgLatency == 0) ? 1 : cfgLatency;
          if (l0Times.size() > 0) begin
            t0 = l0Times.pop_front();
            // R6
            check(cyc - t0 >= minLat, "R6", "L1 after L0 delay", cyc - t0, minLat);
          end else begin
            check(1'b0, "R6", "L1 without pending L0", 0, 1);
          end
          minGap = (cfgSpacing == 0) ? 1 : cfgSpacing;
          if (lastL1 >= 0)
            // R8
            check(cyc - lastL1 >= minGap, "R8", "L1 spacing", cyc - lastL1, minGap);
          lastL1 = cyc;
        end
        if (l0Valid || l1Valid)
          // R5
          check(outstanding <= DEPTH && outstanding >= 0, "R5", "events pending",
                outstanding, DEPTH);
      end
    end
  end

  task automatic runPhase(input logic [11:0] bidMax, input logic [15:0] th0,
                          input logic [15:0] th1, input logic [15:0] lat,
                          input logic [15:0] spc, input int n);
    @(negedge clk);
    cfgBidMax = bidMax; cfgL0Thresh = th0; cfgL1Thresh = th1;
    cfgLatency = lat; cfgSpacing = spc;
    repeat (n) @(negedge clk);
    cfgL0Thresh = 16'h0;
    repeat (700) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  int l0Seen;
  always @(negedge clk) if (!rst && l0Valid) l0Seen++;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R4: zero threshold gives no accepts at all
    l0Seen = 0;
    runPhase(12'd4095, 16'h0000, 16'h8000, 16'd5, 16'd2, 300);
    check(l0Seen == 0, "R4", "accepts with threshold 0", l0Seen, 0);
    // moderate rate, orbit of 100
    runPhase(12'd99, 16'h3000, 16'h8000, 16'd20, 16'd3, 3000);
    // R5: near-certain accepts with long latency fill the queue
    runPhase(12'd4095, 16'hFFFF, 16'hC000, 16'd150, 16'd4, 2000);
    // R2 short orbit, R7 zero latency and zero spacing
    runPhase(12'd3, 16'h6000, 16'h4000, 16'd0, 16'd0, 2000);
    // single-bunch orbit, L1 always accepts
    runPhase(12'd0, 16'h2000, 16'hFFFF, 16'd1, 16'd1, 1000);
    // wide spacing limits L1 rate, L1 always rejects
    runPhase(12'd500, 16'hFFFF, 16'h0000, 16'd7, 16'd12, 2000);
    // R1: reset in mid-run with events queued
    @(negedge clk);
    cfgBidMax = 12'd4095; cfgL0Thresh = 16'hFFFF; cfgL1Thresh = 16'h8000;
    cfgLatency = 16'd100; cfgSpacing = 16'd2;
    repeat (50) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    runPhase(12'd4095, 16'h4000, 16'h8000, 16'd10, 16'd2, 500);
    finishRun();
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "all", "watchdog expired", 0, 1);
    finishRun();
  end
endmodule